// File: doc/BRIEF.md
# Dual-Mapped Data Space Decoder

This block is the data-side interconnect of a small 8-bit microcontroller core. The core presents one 16-bit data address with read and write strobes. The block steers each access to one of four targets:

- a 32-entry general register file;
- a 64-entry core I/O register bank;
- an extended I/O port toward peripherals outside the core;
- internal SRAM.

A second, narrower I/O port carries its own 6-bit address and reaches the same 64 I/O registers. It can write a whole byte. It can also set, clear or test a single bit, but only on the lower half of the bank. Every I/O register can therefore be reached at two addresses: the data address is always the I/O address plus 0x20.

The core status byte and the 16-bit stack pointer live at fixed places in the I/O bank and are brought out as ports. Five pointer-extension bytes also sit in the bank. Two of them are optional: when the parameter `WIDE_PTR_EN` is 0 they are not built. A second parameter, `XIO_PRESENT`, says whether the extended I/O window exists, and so decides where SRAM starts. Reads return data in the same cycle. Writes land on the rising clock edge.

The decoder has five named regions, picked by a unique case on the address:
- `RGN_GPR`: general registers.
- `RGN_IOB`: the I/O bank window.
- `RGN_XIO`: the extended I/O port.
- `RGN_RAM`: SRAM.
- `RGN_VOID`: unmapped.

Top module: `data_space_decoder`

## Requirements
- R1: Data addresses 0x0000–0x001F read and write general register R0–R31, indexed by address bits [4:0].
- R2: A data-port write to address A in 0x0020–0x005F is seen on the I/O port at I/O address A−0x20.
- R3: An I/O-port byte write (io_op = 1) to I/O address N is read back on the data port at address N+0x20.
- R4: On I/O addresses 0x00–0x1F, io_op = 2 sets and io_op = 3 clears the bit selected by io_bit, where bit 0 is the least significant bit (weight 1) and bit 7 the most significant bit (weight 0x80). The other bits keep their values.
- R5: On I/O addresses 0x00–0x1F, io_test equals bit io_bit of the addressed register, in the same cycle.
- R6: On I/O addresses 0x20–0x3F, bit set and bit clear leave the register unchanged, and io_test is 0.
- R7: Data addresses 0x0060–0x00FF assert xio_rd or xio_wr with the matching data strobe. On those addresses xio_addr carries address bits [7:0] and d_rdata returns xio_rdata. Addresses outside that window never assert xio_rd or xio_wr.
- R8: SRAM is read and written from 0x0100 (0x0060 when XIO_PRESENT = 0) through SRAM_LAST, which defaults to 0x045F.
- R9: Data addresses above SRAM_LAST read 0x00, and writes to them change no storage.
- R10: After reset, every general register and every I/O register reads 0x00.
- R11: I/O 0x3F drives core_status. I/O 0x3E and 0x3D drive core_stack bits [15:8] and [7:0]. With WIDE_PTR_EN = 0, I/O 0x39 and 0x3A read 0 and ignore writes, while 0x38, 0x3B and 0x3C store normally.
- R12: When the data port and the I/O port write the same I/O register in one cycle, the data-port value is stored.
- R13: Register reads reflect the address in the same cycle. A write becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_addr | input | 16 | Data-space address |
| d_rd | input | 1 | Data read strobe |
| d_wr | input | 1 | Data write strobe |
| d_wdata | input | 8 | Data write value |
| d_rdata | output | 8 | Data read value (combinational) |
| io_addr | input | 6 | I/O port address |
| io_op | input | 2 | 0 none, 1 byte write, 2 bit set, 3 bit clear |
| io_bit | input | 3 | Bit index for set, clear and test |
| io_wdata | input | 8 | I/O byte write value |
| io_rdata | output | 8 | I/O register read value |
| io_test | output | 1 | Selected bit (lower half only) |
| xio_addr | output | 8 | Extended I/O address (data address [7:0]) |
| xio_rd | output | 1 | Extended I/O read strobe |
| xio_wr | output | 1 | Extended I/O write strobe |
| xio_wdata | output | 8 | Extended I/O write value |
| xio_rdata | input | 8 | Extended I/O read value |
| core_status | output | 8 | Status register (I/O 0x3F) |
| core_stack | output | 16 | Stack pointer (I/O 0x3E:0x3D) |

## Verification
Each region is tried with accesses at its first and last address. The checks at 0x5F/0x60 and 0xFF/0x100 separate an off-by-one in the region bounds from a wrong alias offset.

Alias patterns write on one port and read on the other, in both directions, so a swapped or missing offset shows up.

Bit operations use the two end bits (0 and 7) on lower-half registers and on an upper-half register that holds set bits. This tells a wrong bit weight apart from a missing lower-half gate.

Out-of-range writes target an address whose truncated SRAM index hits a real cell, so missing write gating shows up as corruption. Same-cycle writes from both ports expose the wrong priority.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
    typedef enum logic [2:0] {
        RGN_GPR  = 3'd0,
        RGN_IOB  = 3'd1,
        RGN_XIO  = 3'd2,
        RGN_RAM  = 3'd3,
        RGN_VOID = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        IOP_NONE  = 2'd0,
        IOP_WRITE = 2'd1,
        IOP_SET   = 2'd2,
        IOP_CLR   = 2'd3
    } ioop_e;

    localparam int GPR_N      = 32;
    localparam int IOB_N      = 64;
    localparam int IOB_AW     = 6;
    localparam int IOB_BASE   = 32;
    localparam int XIO_BASE   = 96;
    localparam int XIO_LAST   = 255;
    localparam int RAM_BASE_X = 256;
endpackage

// File: rtl/dsd_region_decode.sv
module dsd_region_decode
    import dsd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter bit XIO_PRESENT = 1'b1,
    parameter int SRAM_LAST   = 16'h045F
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int RAM_BASE = XIO_PRESENT ? RAM_BASE_X : XIO_BASE;
    localparam logic [ADDR_W-1:0] A_IOB  = ADDR_W'(IOB_BASE);
    localparam logic [ADDR_W-1:0] A_XIO  = ADDR_W'(XIO_BASE);
    localparam logic [ADDR_W-1:0] A_XEND = ADDR_W'(XIO_LAST);
    localparam logic [ADDR_W-1:0] A_RAM  = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(SRAM_LAST);

    always_comb begin
        if (addr < A_IOB)                        region = RGN_GPR;
        else if (addr < A_XIO)                   region = RGN_IOB;
        else if (XIO_PRESENT && addr <= A_XEND)  region = RGN_XIO;
        else if (addr >= A_RAM && addr <= A_LAST) region = RGN_RAM;
        else                                     region = RGN_VOID;
    end
endmodule

// File: rtl/dsd_gpr_file.sv
module dsd_gpr_file #(
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata = regs[idx];

    // R1
    gpr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(idx)] == $past(wdata));
endmodule

// File: rtl/dsd_io_bank.sv
module dsd_io_bank
    import dsd_pkg::*;
#(
    parameter bit WIDE_PTR_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_we,
    input  logic [IOB_AW-1:0] d_idx,
    input  logic [7:0]        d_wdata,
    output logic [7:0]        d_rdata,
    input  logic [IOB_AW-1:0] p_addr,
    input  logic [1:0]        p_op,
    input  logic [2:0]        p_bit,
    input  logic [7:0]        p_wdata,
    output logic [7:0]        p_rdata,
    output logic              p_test,
    output logic [7:0]        status_o,
    output logic [15:0]       stack_o
);
    localparam int PTRX_IDX = 57;
    localparam int PTRY_IDX = 58;
    localparam int BIT_HALF = IOB_N / 2;

    logic [7:0] mem [IOB_N];
    logic [7:0] bit_mask;

    assign bit_mask = 8'(1) << p_bit;

    function automatic logic built(input logic [IOB_AW-1:0] a);
        return WIDE_PTR_EN || (a != IOB_AW'(PTRX_IDX) && a != IOB_AW'(PTRY_IDX));
    endfunction

    for (genvar i = 0; i < IOB_N; i++) begin : g_reg
        if (!WIDE_PTR_EN && (i == PTRX_IDX || i == PTRY_IDX)) begin : g_absent
            assign mem[i] = '0;
        end else begin : g_present
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                end else if (d_we && d_idx == IOB_AW'(i)) begin
                    mem[i] <= d_wdata;
                end else if (p_addr == IOB_AW'(i)) begin
                    unique case (ioop_e'(p_op))
                        IOP_NONE:  mem[i] <= mem[i];
                        IOP_WRITE: mem[i] <= p_wdata;
                        IOP_SET:   if (i < BIT_HALF) mem[i] <= mem[i] | bit_mask;
                        IOP_CLR:   if (i < BIT_HALF) mem[i] <= mem[i] & ~bit_mask;
                    endcase
                end
            end
        end
    end

    assign d_rdata  = mem[d_idx];
    assign p_rdata  = mem[p_addr];
    assign p_test   = !p_addr[IOB_AW-1] && p_rdata[p_bit];
    assign status_o = mem[63];
    assign stack_o  = {mem[62], mem[61]};

    // R2
    iob_dwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we && built(d_idx)) |=> mem[$past(d_idx)] == $past(d_wdata));

    // R6
    iob_upper_bitop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_op == IOP_SET || p_op == IOP_CLR) && p_addr[IOB_AW-1]
         && !(d_we && d_idx == p_addr))
        |=> mem[$past(p_addr)] == $past(mem[p_addr]));

    // R12
    iob_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we && p_op != IOP_NONE && d_idx == p_addr && built(d_idx))
        |=> mem[$past(d_idx)] == $past(d_wdata));
endmodule

// File: rtl/dsd_sram.sv
module dsd_sram #(
    parameter int DEPTH = 864,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/data_space_decoder.sv
module data_space_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter bit XIO_PRESENT = 1'b1,
    parameter bit WIDE_PTR_EN = 1'b0,
    parameter int SRAM_LAST   = 16'h045F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_rd,
    input  logic              d_wr,
    input  logic [7:0]        d_wdata,
    output logic [7:0]        d_rdata,
    input  logic [5:0]        io_addr,
    input  logic [1:0]        io_op,
    input  logic [2:0]        io_bit,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_test,
    output logic [7:0]        xio_addr,
    output logic              xio_rd,
    output logic              xio_wr,
    output logic [7:0]        xio_wdata,
    input  logic [7:0]        xio_rdata,
    output logic [7:0]        core_status,
    output logic [15:0]       core_stack
);
    localparam int RAM_BASE  = XIO_PRESENT ? RAM_BASE_X : XIO_BASE;
    localparam int RAM_DEPTH = SRAM_LAST - RAM_BASE + 1;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam int GPR_AW    = $clog2(GPR_N);

    region_e            region;
    logic [7:0]         gpr_rd, iob_rd, ram_rd;
    logic [IOB_AW-1:0]  iob_idx;
    logic [RAM_AW-1:0]  ram_idx;

    dsd_region_decode #(
        .ADDR_W(ADDR_W), .XIO_PRESENT(XIO_PRESENT), .SRAM_LAST(SRAM_LAST)
    ) u_decode (
        .addr(d_addr), .region(region)
    );

    assign iob_idx = IOB_AW'(d_addr - ADDR_W'(IOB_BASE));
    assign ram_idx = RAM_AW'(d_addr - ADDR_W'(RAM_BASE));

    dsd_gpr_file #(.N(GPR_N)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .we(d_wr && region == RGN_GPR),
        .idx(d_addr[GPR_AW-1:0]), .wdata(d_wdata), .rdata(gpr_rd)
    );

    dsd_io_bank #(.WIDE_PTR_EN(WIDE_PTR_EN)) u_iob (
        .clk(clk), .rst_n(rst_n),
        .d_we(d_wr && region == RGN_IOB), .d_idx(iob_idx),
        .d_wdata(d_wdata), .d_rdata(iob_rd),
        .p_addr(io_addr), .p_op(io_op), .p_bit(io_bit), .p_wdata(io_wdata),
        .p_rdata(io_rdata), .p_test(io_test),
        .status_o(core_status), .stack_o(core_stack)
    );

    dsd_sram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(d_wr && region == RGN_RAM),
        .idx(ram_idx), .wdata(d_wdata), .rdata(ram_rd)
    );

    assign xio_addr  = d_addr[7:0];
    assign xio_wdata = d_wdata;
    assign xio_rd    = d_rd && region == RGN_XIO;
    assign xio_wr    = d_wr && region == RGN_XIO;

    always_comb begin
        unique case (region)
            RGN_GPR:  d_rdata = gpr_rd;
            RGN_IOB:  d_rdata = iob_rd;
            RGN_XIO:  d_rdata = xio_rdata;
            RGN_RAM:  d_rdata = ram_rd;
            default:  d_rdata = 8'h00;
        endcase
    end

    // R7
    xio_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xio_rd || xio_wr) |-> (d_addr >= ADDR_W'(XIO_BASE) && d_addr <= ADDR_W'(XIO_LAST)));

    // R9
    void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_addr > ADDR_W'(SRAM_LAST)) |-> d_rdata == 8'h00);
endmodule

// File: tb/data_space_decoder_tb.sv
`timescale 1ns/1ps
module data_space_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] d_addr = '0;
    logic        d_rd = 1'b0, d_wr = 1'b0;
    logic [7:0]  d_wdata = '0, d_rdata;
    logic [5:0]  io_addr = '0;
    logic [1:0]  io_op = '0;
    logic [2:0]  io_bit = '0;
    logic [7:0]  io_wdata = '0, io_rdata;
    logic        io_test;
    logic [7:0]  xio_addr, xio_wdata, xio_rdata = '0;
    logic        xio_rd, xio_wr;
    logic [7:0]  core_status;
    logic [15:0] core_stack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    data_space_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .d_addr(d_addr), .d_rd(d_rd), .d_wr(d_wr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .io_addr(io_addr), .io_op(io_op), .io_bit(io_bit), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_test(io_test),
        .xio_addr(xio_addr), .xio_rd(xio_rd), .xio_wr(xio_wr),
        .xio_wdata(xio_wdata), .xio_rdata(xio_rdata),
        .core_status(core_status), .core_stack(core_stack)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dwrite(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        d_addr = a; d_wdata = v; d_wr = 1'b1;
        @(negedge clk);
        d_wr = 1'b0;
    endtask

    task automatic dread(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        d_addr = a;
        #1 check(req, {8'h0, d_rdata}, {8'h0, exp});
    endtask

    task automatic ioact(input logic [5:0] a, input logic [1:0] op, input logic [2:0] b,
                         input logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_op = op; io_bit = b; io_wdata = v;
        @(negedge clk);
        io_op = 2'd0;
    endtask

    task automatic ioread(input string req, input logic [5:0] a, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_op = 2'd0;
        #1 check(req, {8'h0, io_rdata}, {8'h0, exp});
    endtask

    task automatic t_reset;
        dread("R10", 16'h0000, 8'h00);
        dread("R10", 16'h001F, 8'h00);
        dread("R10", 16'h0020, 8'h00);
        dread("R10", 16'h005F, 8'h00);
        check("R10", {8'h0, core_status}, 16'h0);
        check("R10", core_stack, 16'h0);
    endtask

    task automatic t_gpr;
        dwrite(16'h0005, 8'hA5);
        dwrite(16'h001F, 8'h3C);
        dread("R1", 16'h0005, 8'hA5);
        dread("R1", 16'h001F, 8'h3C);
        dread("R1", 16'h0004, 8'h00);
    endtask

    task automatic t_alias;
        dwrite(16'h0030, 8'h5A);
        ioread("R2", 6'h10, 8'h5A);
        dwrite(16'h005F, 8'h0C);
        ioread("R2", 6'h3F, 8'h0C);
        ioact(6'h2E, 2'd1, 3'd0, 8'hC3);
        dread("R3", 16'h004E, 8'hC3);
        ioact(6'h00, 2'd1, 3'd0, 8'h44);
        dread("R3", 16'h0020, 8'h44);
    endtask

    task automatic t_bits;
        dwrite(16'h0027, 8'h00);
        ioact(6'h07, 2'd2, 3'd0, 8'h00);
        ioread("R4", 6'h07, 8'h01);
        ioact(6'h07, 2'd2, 3'd7, 8'h00);
        ioread("R4", 6'h07, 8'h81);
        ioact(6'h07, 2'd3, 3'd0, 8'h00);
        ioread("R4", 6'h07, 8'h80);
        @(negedge clk); io_addr = 6'h07; io_bit = 3'd7;
        #1 check("R5", {15'h0, io_test}, 16'h1);
        io_bit = 3'd0;
        #1 check("R5", {15'h0, io_test}, 16'h0);
    endtask

    task automatic t_upper;
        dwrite(16'h0045, 8'h0F);
        ioact(6'h25, 2'd2, 3'd7, 8'h00);
        ioread("R6", 6'h25, 8'h0F);
        ioact(6'h25, 2'd3, 3'd0, 8'h00);
        ioread("R6", 6'h25, 8'h0F);
        @(negedge clk); io_addr = 6'h25; io_bit = 3'd0;
        #1 check("R6", {15'h0, io_test}, 16'h0);
    endtask

    task automatic t_special;
        ioact(6'h3F, 2'd1, 3'd0, 8'h81);
        ioact(6'h3E, 2'd1, 3'd0, 8'h12);
        dwrite(16'h005D, 8'h34);
        #1 check("R11", {8'h0, core_status}, 16'h0081);
        check("R11", core_stack, 16'h1234);
        ioact(6'h39, 2'd1, 3'd0, 8'hFF);
        dread("R11", 16'h0059, 8'h00);
        dwrite(16'h005A, 8'hEE);
        ioread("R11", 6'h3A, 8'h00);
        dwrite(16'h005B, 8'h77);
        ioread("R11", 6'h3B, 8'h77);
        ioact(6'h38, 2'd1, 3'd0, 8'h21);
        dread("R11", 16'h0058, 8'h21);
    endtask

    task automatic t_xio;
        @(negedge clk);
        d_addr = 16'h0060; d_rd = 1'b1; xio_rdata = 8'h9E;
        #1 check("R7", {8'h0, d_rdata}, 16'h009E);
        check("R7", {7'h0, xio_rd, xio_addr}, 16'h0160);
        d_addr = 16'h005F;
        #1 check("R7", {15'h0, xio_rd}, 16'h0);
        d_addr = 16'h0100;
        #1 check("R7", {15'h0, xio_rd}, 16'h0);
        d_rd = 1'b0;
        d_addr = 16'h00FF; d_wr = 1'b1; d_wdata = 8'h6B;
        #1 check("R7", {7'h0, xio_wr, xio_wdata}, 16'h016B);
        @(negedge clk); d_wr = 1'b0;
    endtask

    task automatic t_sram;
        dwrite(16'h0100, 8'h11);
        dwrite(16'h045F, 8'h22);
        dwrite(16'h0400, 8'h33);
        dread("R8", 16'h0100, 8'h11);
        dread("R8", 16'h045F, 8'h22);
        dread("R8", 16'h0400, 8'h33);
    endtask

    task automatic t_void;
        dwrite(16'h1000, 8'hEE);
        dread("R9", 16'h1000, 8'h00);
        dread("R9", 16'h0460, 8'h00);
        dread("R9", 16'h0400, 8'h33);
    endtask

    task automatic t_collide;
        @(negedge clk);
        d_addr = 16'h0030; d_wdata = 8'hAA; d_wr = 1'b1;
        io_addr = 6'h10; io_op = 2'd1; io_wdata = 8'h55;
        @(negedge clk);
        d_wr = 1'b0; io_op = 2'd0;
        ioread("R12", 6'h10, 8'hAA);
        @(negedge clk);
        d_addr = 16'h0027; d_wdata = 8'hF0; d_wr = 1'b1;
        io_addr = 6'h07; io_op = 2'd2; io_bit = 3'd0;
        @(negedge clk);
        d_wr = 1'b0; io_op = 2'd0;
        dread("R12", 16'h0027, 8'hF0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        d_addr = 16'h0008; d_wdata = 8'h66; d_wr = 1'b1;
        #1 check("R13", {8'h0, d_rdata}, 16'h0000);
        @(posedge clk); #1;
        check("R13", {8'h0, d_rdata}, 16'h0066);
        d_wr = 1'b0;
        d_addr = 16'h0005;
        #1 check("R13", {8'h0, d_rdata}, 16'h00A5);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_gpr;
        t_alias;
        t_bits;
        t_upper;
        t_special;
        t_xio;
        t_sram;
        t_void;
        t_collide;
        t_timing;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule